// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers up to 32 active-high, level-sensitive interrupt sources and drives four level outputs: two ordinary interrupt lines, one for each of two processors, and two machine-check lines, one for each processor. Each raw source passes through a two-flop synchroniser into a read-only status word. Four independent 32-bit enable masks, one per output, decide which sources reach which line. An output stays high for as long as at least one enabled source is active. There is no acknowledge register. Software quiets a line either by servicing the device until its request drops, or by clearing the mask bit.

Software sees the block through a small 32-bit register bus: byte address, write enable, write data and combinational read data. Offset 0x00 returns the synchronised status. The four masks sit at consecutive word offsets 0x10, 0x14, 0x18 and 0x1C. Because a source can be enabled in several masks at once, one request can raise an interrupt on both processors, or an interrupt and a machine check, at the same time. Picking which pending source to service first is left to software.

The bus decoder resolves each address into one of three selections, handled by a unique case. SEL_STATUS covers offset 0x00. SEL_MASK covers the four mask words and carries the mask index. SEL_NONE covers every other address, including any address that is not word aligned.

Top module: `lvl_irq_agg`

## Requirements
- R1: While reset is asserted and on the first cycles after it, all four outputs are 0 and all four mask registers read 0.
- R2: A change on a source input appears in the status word at offset 0x00 after exactly two rising clock edges. Status bit i holds source i.
- R3: Status bits 31 to 17 and bit 6 always read 0, and an active source on any of these positions never raises an output, even when every mask bit is set.
- R4: The masks are read/write. Offset 0x10 enables sources onto processor 0's interrupt line and offset 0x14 onto processor 1's. Offset 0x18 enables sources onto processor 0's machine-check line and offset 0x1C onto processor 1's. A read returns the last value written.
- R5: Mask bit value 1 enables the matching source and value 0 blocks it. Each output is registered and equals the OR over all bits of (status AND its mask). It follows a mask write or a status change one rising edge later.
- R6: The masks are independent: a single active source enabled in several masks asserts every one of those outputs at the same time.
- R7: There is no acknowledge. An output stays high while its enabled source stays active, even when the status word is read. It drops only after the source deasserts or the mask bit is cleared.
- R8: Reads of any address other than 0x00, 0x10, 0x14, 0x18 and 0x1C, including addresses that are not word aligned, return 0. Writes to offset 0x00 or to such addresses change no mask and no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable; the write takes effect on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_lvl | input | 32 | Raw level-sensitive interrupt sources, active high |
| cpu_irq | output | 2 | Interrupt line for processor 0 (bit 0) and processor 1 (bit 1) |
| cpu_mchk | output | 2 | Machine-check line for processor 0 (bit 0) and processor 1 (bit 1) |

## Verification
The hardest case to set up from the ports is showing that nothing acknowledges an interrupt. The stimulus holds an enabled source high for many cycles, then reads the status word, then writes zero to the status address. It checks that every output and the status value are unchanged after each of these accesses. Only then does it clear one mask, and later deassert the source, counting the edges until each line falls. The reserved positions are reached by driving all ones on the sources while every bit of a mask is set, and then checking the status value and an output that must stay low.

// File: rtl/lvl_irq_agg_pkg.sv
package lvl_irq_agg_pkg;

    localparam int DATA_W     = 32;
    localparam int NUM_MASK   = 4;
    localparam int STATUS_OFF = 'h00;
    localparam int MASK_BASE  = 'h10;

    // Bus decode result.
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_MASK   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/lvl_irq_sync.sv
module lvl_irq_sync #(
    parameter int                 SRC_W      = 32,
    parameter logic [SRC_W-1:0]   VALID_BITS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_lvl,
    output logic [SRC_W-1:0] status
);

    logic [SRC_W-1:0] meta_q;
    logic [SRC_W-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stat_q <= '0;
        end else begin
            meta_q <= src_lvl & VALID_BITS;
            stat_q <= meta_q;
        end
    end

    assign status = stat_q;

    // Counts edges since reset so the latency check never looks before reset.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            age_q <= 2'd0;
        else if (age_q != 2'd2)
            age_q <= age_q + 2'd1;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (status == ($past(src_lvl, 2) & VALID_BITS))); // R2

endmodule

// File: rtl/lvl_irq_regs.sv
module lvl_irq_regs
    import lvl_irq_agg_pkg::*;
#(
    parameter int               ADDR_W     = 8,
    parameter logic [DATA_W-1:0] VALID_BITS = '1,
    localparam int              IDX_W      = $clog2(NUM_MASK)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic                              bus_we,
    input  logic [DATA_W-1:0]                 bus_wdata,
    input  logic [DATA_W-1:0]                 status,
    output logic [DATA_W-1:0]                 bus_rdata,
    output logic [NUM_MASK-1:0][DATA_W-1:0]   masks
);

    reg_sel_e             sel;
    logic [IDX_W-1:0]     sel_idx;
    logic [NUM_MASK-1:0][DATA_W-1:0] mask_q;

    // Address decode: status word, one of the mask words, or nothing.
    always_comb begin
        sel     = SEL_NONE;
        sel_idx = '0;
        if (bus_addr == ADDR_W'(STATUS_OFF)) begin
            sel = SEL_STATUS;
        end else begin
            for (int t = 0; t < NUM_MASK; t++) begin
                if (bus_addr == ADDR_W'(MASK_BASE + 4 * t)) begin
                    sel     = SEL_MASK;
                    sel_idx = IDX_W'(t);
                end
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: bus_rdata = status;
            SEL_MASK:   bus_rdata = mask_q[sel_idx];
            default:    bus_rdata = '0;
        endcase
    end

    for (genvar g = 0; g < NUM_MASK; g++) begin : g_mask
        logic hit;
        assign hit = bus_we && (sel == SEL_MASK) && (sel_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mask_q[g] <= '0;
            else if (hit)
                mask_q[g] <= bus_wdata;
        end

        AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(MASK_BASE + 4 * g))
            |=> (masks[g] == $past(bus_wdata))); // R4

        AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(bus_we && bus_addr == ADDR_W'(MASK_BASE + 4 * g))
            |=> $stable(masks[g])); // R8
    end

    assign masks = mask_q;

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(STATUS_OFF)) |-> ((bus_rdata & ~VALID_BITS) == '0)); // R3

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R8

endmodule

// File: rtl/lvl_irq_outgen.sv
module lvl_irq_outgen
    import lvl_irq_agg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [DATA_W-1:0]               status,
    input  logic [NUM_MASK-1:0][DATA_W-1:0] masks,
    output logic [NUM_MASK-1:0]             lines
);

    for (genvar g = 0; g < NUM_MASK; g++) begin : g_line
        logic line_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                line_q <= 1'b0;
            else
                line_q <= |(status & masks[g]);
        end

        assign lines[g] = line_q;

        AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (masks[g] == '0) |=> !lines[g]); // R5
    end

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
    import lvl_irq_agg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [DATA_W-1:0] VALID_BITS = 32'h0001_FFBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] src_lvl,
    output logic [1:0]        cpu_irq,
    output logic [1:0]        cpu_mchk
);

    logic [DATA_W-1:0]               status;
    logic [NUM_MASK-1:0][DATA_W-1:0] masks;
    logic [NUM_MASK-1:0]             lines;

    lvl_irq_sync #(
        .SRC_W      (DATA_W),
        .VALID_BITS (VALID_BITS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_lvl (src_lvl),
        .status  (status)
    );

    lvl_irq_regs #(
        .ADDR_W     (ADDR_W),
        .VALID_BITS (VALID_BITS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .status    (status),
        .bus_rdata (bus_rdata),
        .masks     (masks)
    );

    lvl_irq_outgen u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .masks  (masks),
        .lines  (lines)
    );

    // Mask words 0,1 feed the interrupt lines, words 2,3 the machine-check lines.
    assign cpu_irq  = lines[1:0];
    assign cpu_mchk = lines[3:2];

    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> (lines == '0)); // R7

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (lines != '0) |-> ($past(status) != '0)); // R5

    AST_RSVD_NEVER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~VALID_BITS) == '0)); // R3

endmodule

// File: tb/tb_lvl_irq_agg.sv
module tb_lvl_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] src_lvl;
    logic [1:0]  cpu_irq;
    logic [1:0]  cpu_mchk;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    localparam logic [31:0] VALID = 32'h0001_FFBF;

    always #5 clk = ~clk;

    lvl_irq_agg dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lvl   (src_lvl),
        .cpu_irq   (cpu_irq),
        .cpu_mchk  (cpu_mchk)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        src_lvl = 32'hFFFF_FFFF;
        cyc(3);
        check("R1", "irq during reset", {30'd0, cpu_irq}, 32'd0);
        check("R1", "mchk during reset", {30'd0, cpu_mchk}, 32'd0);
        src_lvl = '0;
        rst_n = 1'b1;
        cyc(4);
        for (int i = 0; i < 4; i++) begin
            rd(8'h10 + 8'(4 * i), d);
            check("R1", "mask after reset", d, 32'd0);
        end
        check("R1", "outputs after reset", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        src_lvl = 32'h0000_0001;
        cyc(1);
        rd(8'h00, d);
        check("R2", "status after one edge", d, 32'd0);
        cyc(1);
        rd(8'h00, d);
        check("R2", "status after two edges", d, 32'h1);
        src_lvl = 32'h0000_A5A4;
        cyc(2);
        rd(8'h00, d);
        check("R2", "status pattern", d, 32'h0000_A5A4);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        wr(8'h10, 32'hFFFF_FFFF);
        src_lvl = 32'hFFFE_0040;
        cyc(3);
        rd(8'h00, d);
        check("R3", "reserved-only status", d, 32'd0);
        check("R3", "reserved-only irq0", {31'd0, cpu_irq[0]}, 32'd0);
        src_lvl = 32'hFFFF_FFFF;
        cyc(2);
        rd(8'h00, d);
        check("R3", "all-ones status", d, VALID);
        src_lvl = '0;
        wr(8'h10, 32'd0);
        cyc(3);
    endtask

    task automatic t_mask_rw();
        logic [31:0] d;
        logic [31:0] pat [4];
        pat[0] = 32'h1234_5678;
        pat[1] = 32'h8765_4321;
        pat[2] = 32'hDEAD_BEEF;
        pat[3] = 32'h0F0F_F0F0;
        for (int i = 0; i < 4; i++) wr(8'h10 + 8'(4 * i), pat[i]);
        for (int i = 0; i < 4; i++) begin
            rd(8'h10 + 8'(4 * i), d);
            check("R4", "mask readback", d, pat[i]);
        end
        for (int i = 0; i < 4; i++) wr(8'h10 + 8'(4 * i), 32'd0);
        cyc(2);
    endtask

    task automatic t_timing();
        src_lvl = 32'h0000_0008;
        cyc(3);
        check("R5", "blocked by zero mask", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
        wr(8'h10, 32'h0000_0008);
        check("R5", "before update edge", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
        cyc(1);
        check("R5", "one edge after write", {28'd0, cpu_mchk, cpu_irq}, 32'h1);
        wr(8'h10, 32'hFFFF_FFF7);
        cyc(1);
        check("R5", "other bits enabled only", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
        wr(8'h10, 32'd0);
        src_lvl = '0;
        cyc(3);
    endtask

    task automatic t_indep();
        for (int i = 0; i < 4; i++) wr(8'h10 + 8'(4 * i), 32'h0000_0020);
        src_lvl = 32'h0000_0020;
        cyc(3);
        check("R6", "all four lines", {28'd0, cpu_mchk, cpu_irq}, 32'hF);
    endtask

    task automatic t_noack();
        logic [31:0] d;
        cyc(6);
        check("R7", "held while active", {28'd0, cpu_mchk, cpu_irq}, 32'hF);
        rd(8'h00, d);
        cyc(2);
        check("R7", "after status read", {28'd0, cpu_mchk, cpu_irq}, 32'hF);
        wr(8'h00, 32'd0);
        cyc(1);
        rd(8'h00, d);
        check("R8", "status after write", d, 32'h20);
        check("R7", "after status write", {28'd0, cpu_mchk, cpu_irq}, 32'hF);
        wr(8'h14, 32'd0);
        check("R7", "mask clear, before edge", {28'd0, cpu_mchk, cpu_irq}, 32'hF);
        cyc(1);
        check("R7", "mask clear drops irq1", {28'd0, cpu_mchk, cpu_irq}, 32'hD);
        src_lvl = '0;
        cyc(2);
        check("R7", "source low, two edges", {28'd0, cpu_mchk, cpu_irq}, 32'hD);
        cyc(1);
        check("R7", "source low, three edges", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        logic [7:0] bad [6];
        bad[0] = 8'h04; bad[1] = 8'h11; bad[2] = 8'h20;
        bad[3] = 8'h13; bad[4] = 8'hFC; bad[5] = 8'h0C;
        src_lvl = 32'h0000_0003;
        cyc(2);
        for (int i = 0; i < 6; i++) begin
            rd(bad[i], d);
            check("R8", "unmapped read", d, 32'd0);
        end
        for (int i = 0; i < 6; i++) wr(bad[i], 32'hFFFF_FFFF);
        rd(8'h10, d); check("R8", "mask0 kept", d, 32'h20);
        rd(8'h14, d); check("R8", "mask1 kept", d, 32'h0);
        rd(8'h18, d); check("R8", "mask2 kept", d, 32'h20);
        rd(8'h1C, d); check("R8", "mask3 kept", d, 32'h20);
        rd(8'h00, d); check("R8", "status kept", d, 32'h3);
        check("R8", "outputs quiet", {28'd0, cpu_mchk, cpu_irq}, 32'd0);
    endtask

    initial begin
        bus_addr = '0;
        bus_we = 1'b0;
        bus_wdata = '0;
        src_lvl = '0;
        rst_n = 1'b0;
        @(negedge clk);
        t_reset();
        t_sync();
        t_reserved();
        t_mask_rw();
        t_timing();
        t_indep();
        t_noack();
        t_unmapped();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule